// File: doc/BRIEF.md
# Adaptive Page-Cache Replacement Controller

This block manages a fixed set of local page frames that hold replicated copies of remote pages. Every other page is served in remote-access mode and takes no frame. The block grants frames to new allocations and to relocation (upgrade) requests. It tracks a reference bit per frame. When the free pool falls below a low watermark, it runs a clock-style second-chance sweep that evicts cold frames until a high watermark is reached.

A sweep can end without reaching the high watermark. The block then treats the system as thrashing and backs off in three ways:
- new pages are placed in remote-access mode;
- the relocation threshold published to the rest of the memory system is raised;
- the wait between sweeps is doubled.

A later successful sweep that finds more cold pages than the one before it lowers the threshold again. The surrounding logic performs cache flushing and page-table updates on each eviction command.

Top module: `pgc_repl_ctrl`

## Requirements
- R1: The low watermark is floor(5*T/100) and the high watermark is floor(7*T/100), where T is `total_pages_i`. A sweep starts only when the free-frame count is below the low watermark and at least the current scan interval has elapsed since the previous sweep ended.
- R2: Allocation when the pool is non-empty and no backoff is active:
  - the response appears one cycle after the request, with `alloc_repl_o`=1 (replicated mode);
  - `alloc_idx_o` is the lowest-numbered free frame;
  - the frame is taken.
- R3: An allocation made while the pool is empty, or while backoff is active, returns `alloc_repl_o`=0 (remote-access mode) and takes no frame.
- R4: A sweep examines one frame per cycle and evicts only occupied frames:
  - a frame whose reference bit is set has the bit cleared and is kept;
  - a frame whose reference bit is clear is evicted, with `evict_o`=1 and `evict_idx_o` naming the frame in that cycle;
  - a free frame is skipped.
- R5: A sweep stops as soon as the free count reaches the high watermark, and counts as successful. It counts as failed if it covers all frames without reaching the high watermark.
- R6: A failed sweep does three things:
  - it pulses `thrash_o` for one cycle;
  - it raises `threshold_o` by 8, saturating at THR_MAX (64), from the reset value of 32;
  - it activates backoff.

  A successful sweep clears backoff.
- R7: A successful sweep that evicted more frames than the previous sweep lowers `threshold_o` by 8, to no less than 32. A failed sweep never lowers it.
- R8: Each failed sweep doubles the scan interval, up to INTV_MAX (64 cycles). A successful sweep returns the interval to INTV_BASE (8 cycles).
- R9: A relocation request is granted one cycle later (`reloc_ok_o`=1, frame `reloc_idx_o` = lowest free frame) only when three conditions hold: a free frame exists, `threshold_o` is below THR_MAX, and no allocation is requested in the same cycle. Otherwise the response shows `reloc_ok_o`=0.
- R10: The sweep pointer persists across sweeps. A new sweep starts at the frame after the last one examined, wrapping from the last frame to frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| total_pages_i | input | TW | Total page count used for the watermarks |
| alloc_req_i | input | 1 | New page allocation request |
| reloc_req_i | input | 1 | Relocation (upgrade to replicated) request |
| ref_set_i | input | 1 | Set the reference bit of frame `ref_idx_i` |
| ref_idx_i | input | log2(N_FR) | Frame whose reference bit is set |
| alloc_vld_o | output | 1 | Allocation response valid |
| alloc_repl_o | output | 1 | 1 = replicated mode, 0 = remote-access mode |
| alloc_idx_o | output | log2(N_FR) | Frame granted to a replicated allocation |
| reloc_vld_o | output | 1 | Relocation response valid |
| reloc_ok_o | output | 1 | Relocation granted |
| reloc_idx_o | output | log2(N_FR) | Frame granted to the relocation |
| evict_o | output | 1 | Evict frame `evict_idx_o` this cycle |
| evict_idx_o | output | log2(N_FR) | Frame being evicted |
| threshold_o | output | THW | Current relocation threshold |
| thrash_o | output | 1 | One-cycle pulse on a failed sweep |

## Verification
The ports expose internal state in three ways:
- A corrupted occupancy or reference vector shows up as the wrong frame index on the next grant, or as a wrong eviction index or count during the next sweep.
- A lost sweep pointer shows up on the first eviction of the following sweep.
- A wrong threshold or interval update is visible on `threshold_o` one cycle after the sweep ends. It also shows up as a wrong spacing between successive `thrash_o` pulses, which equals the interval plus 66 cycles for a full sweep.

The directed scenarios drive the block through a failure, a recovery with partial eviction, and a sequence of saturating failures, so that each of these shows up within one sweep.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DONE} scan_st_e;

  function automatic logic [31:0] pct_of(input logic [31:0] total, input int unsigned pct);
    return (total * pct) / 32'd100;
  endfunction
endpackage

// File: rtl/pgc_frame_table.sv
module pgc_frame_table #(
  parameter int N_FR = 64,
  localparam int IW = $clog2(N_FR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          ref_set_i,
  input  logic [IW-1:0] ref_idx_i,
  input  logic          probe_i,
  input  logic [IW-1:0] probe_idx_i,
  output logic          any_free_o,
  output logic [IW-1:0] first_free_o,
  output logic [IW:0]   free_cnt_o,
  output logic          cold_o
);
  logic [N_FR-1:0] used_q, used_d, ref_q, ref_d;
  logic [IW:0]     n_used;
  logic            probe_hot, probe_used;

  always_comb begin
    any_free_o   = 1'b0;
    first_free_o = '0;
    for (int i = N_FR - 1; i >= 0; i--) begin
      if (!used_q[i]) begin
        any_free_o   = 1'b1;
        first_free_o = IW'(i);
      end
    end
  end

  always_comb begin
    n_used = '0;
    for (int i = 0; i < N_FR; i++) n_used = n_used + {{IW{1'b0}}, used_q[i]};
    free_cnt_o = (IW+1)'(N_FR) - n_used;
  end

  // same-cycle reference counts as a hit
  assign probe_used = used_q[probe_idx_i];
  assign probe_hot  = ref_q[probe_idx_i] | (ref_set_i && (ref_idx_i == probe_idx_i));
  assign cold_o     = probe_i && probe_used && !probe_hot;

  always_comb begin
    used_d = used_q;
    ref_d  = ref_q;
    if (probe_i && probe_used) ref_d[probe_idx_i] = 1'b0;
    if (cold_o) used_d[probe_idx_i] = 1'b0;
    if (ref_set_i && used_q[ref_idx_i]) ref_d[ref_idx_i] = 1'b1;
    if (take_i && any_free_o) begin
      used_d[first_free_o] = 1'b1;
      ref_d[first_free_o]  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      ref_q  <= '0;
    end else begin
      used_q <= used_d;
      ref_q  <= ref_d;
    end
  end
endmodule

// File: rtl/pgc_scan_engine.sv
module pgc_scan_engine #(
  parameter int N_FR = 64,
  localparam int IW = $clog2(N_FR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          target_met_i,
  input  logic          cold_i,
  output logic          idle_o,
  output logic          probe_o,
  output logic [IW-1:0] probe_idx_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          more_o
);
  import pgc_pkg::*;

  scan_st_e    st_q;
  logic [IW-1:0] ptr_q, seen_q;
  logic [IW:0]   cur_q, prev_q;
  logic          last_exam;

  assign idle_o      = (st_q == ST_IDLE);
  assign probe_o     = (st_q == ST_SCAN) && !target_met_i;
  assign probe_idx_o = ptr_q;
  assign last_exam   = (seen_q == IW'(N_FR - 1));
  assign done_o      = (st_q == ST_DONE);
  assign ok_o        = target_met_i;
  assign more_o      = cur_q > prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      seen_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_SCAN;
          seen_q <= '0;
          cur_q  <= '0;
        end
        ST_SCAN: begin
          if (target_met_i) st_q <= ST_DONE;
          else begin
            if (cold_i) cur_q <= cur_q + 1'b1;
            ptr_q  <= (ptr_q == IW'(N_FR - 1)) ? '0 : ptr_q + 1'b1;
            seen_q <= seen_q + 1'b1;
            if (last_exam) st_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          prev_q <= cur_q;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgc_backoff.sv
module pgc_backoff #(
  parameter int THW       = 8,
  parameter int THR_INIT  = 32,
  parameter int THR_STEP  = 8,
  parameter int THR_MAX   = 64,
  parameter int INTV_BASE = 8,
  parameter int INTV_MAX  = 64,
  localparam int CW = $clog2(INTV_MAX + 1) + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           done_i,
  input  logic           ok_i,
  input  logic           more_i,
  output logic [THW-1:0] thr_o,
  output logic           backoff_o,
  output logic           ready_o,
  output logic           thrash_o
);
  logic [THW-1:0] thr_q;
  logic [THW:0]   thr_up;
  logic [CW-1:0]  intv_q, timer_q;
  logic [CW:0]    intv_dbl;

  assign thr_up   = {1'b0, thr_q} + (THW+1)'(THR_STEP);
  assign intv_dbl = {intv_q, 1'b0};
  assign thr_o    = thr_q;
  assign ready_o  = timer_q >= intv_q;
  assign thrash_o = done_i && !ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q     <= THW'(THR_INIT);
      intv_q    <= CW'(INTV_BASE);
      timer_q   <= '0;
      backoff_o <= 1'b0;
    end else begin
      if (done_i) timer_q <= '0;
      else if (timer_q < CW'(INTV_MAX)) timer_q <= timer_q + 1'b1;
      if (done_i && !ok_i) begin
        backoff_o <= 1'b1;
        thr_q     <= (thr_up > (THW+1)'(THR_MAX)) ? THW'(THR_MAX) : thr_up[THW-1:0];
        intv_q    <= (intv_dbl > (CW+1)'(INTV_MAX)) ? CW'(INTV_MAX) : intv_dbl[CW-1:0];
      end else if (done_i) begin
        backoff_o <= 1'b0;
        intv_q    <= CW'(INTV_BASE);
        if (more_i)
          thr_q <= (thr_q < THW'(THR_INIT + THR_STEP)) ? THW'(THR_INIT) : thr_q - THW'(THR_STEP);
      end
    end
  end
endmodule

// File: rtl/pgc_repl_ctrl.sv
module pgc_repl_ctrl #(
  parameter int N_FR      = 64,
  parameter int TW        = 16,
  parameter int THW       = 8,
  parameter int THR_INIT  = 32,
  parameter int THR_STEP  = 8,
  parameter int THR_MAX   = 64,
  parameter int INTV_BASE = 8,
  parameter int INTV_MAX  = 64,
  localparam int IW = $clog2(N_FR)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [TW-1:0]  total_pages_i,
  input  logic           alloc_req_i,
  input  logic           reloc_req_i,
  input  logic           ref_set_i,
  input  logic [IW-1:0]  ref_idx_i,
  output logic           alloc_vld_o,
  output logic           alloc_repl_o,
  output logic [IW-1:0]  alloc_idx_o,
  output logic           reloc_vld_o,
  output logic           reloc_ok_o,
  output logic [IW-1:0]  reloc_idx_o,
  output logic           evict_o,
  output logic [IW-1:0]  evict_idx_o,
  output logic [THW-1:0] threshold_o,
  output logic           thrash_o
);
  import pgc_pkg::*;

  logic          any_free, cold, probe, idle, done, ok, more, backoff, ready;
  logic [IW-1:0] first_free, probe_idx;
  logic [IW:0]   free_cnt;
  logic [31:0]   wm_lo, wm_hi;
  logic          below_lo, target_met, repl_ok, reloc_go, take;

  assign wm_lo      = pct_of(32'(total_pages_i), 5);
  assign wm_hi      = pct_of(32'(total_pages_i), 7);
  assign below_lo   = 32'(free_cnt) < wm_lo;
  assign target_met = 32'(free_cnt) >= wm_hi;

  assign repl_ok  = any_free && !backoff;
  assign reloc_go = reloc_req_i && !alloc_req_i && any_free && (threshold_o < THW'(THR_MAX));
  assign take     = (alloc_req_i && repl_ok) || reloc_go;

  pgc_frame_table #(.N_FR(N_FR)) u_tab (
    .clk_i, .rst_ni, .take_i(take), .ref_set_i, .ref_idx_i,
    .probe_i(probe), .probe_idx_i(probe_idx),
    .any_free_o(any_free), .first_free_o(first_free),
    .free_cnt_o(free_cnt), .cold_o(cold)
  );

  pgc_scan_engine #(.N_FR(N_FR)) u_scan (
    .clk_i, .rst_ni, .start_i(idle && below_lo && ready),
    .target_met_i(target_met), .cold_i(cold), .idle_o(idle),
    .probe_o(probe), .probe_idx_o(probe_idx),
    .done_o(done), .ok_o(ok), .more_o(more)
  );

  pgc_backoff #(
    .THW(THW), .THR_INIT(THR_INIT), .THR_STEP(THR_STEP), .THR_MAX(THR_MAX),
    .INTV_BASE(INTV_BASE), .INTV_MAX(INTV_MAX)
  ) u_bo (
    .clk_i, .rst_ni, .done_i(done), .ok_i(ok), .more_i(more),
    .thr_o(threshold_o), .backoff_o(backoff), .ready_o(ready), .thrash_o(thrash_o)
  );

  assign evict_o     = cold;
  assign evict_idx_o = probe_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_vld_o  <= 1'b0;
      alloc_repl_o <= 1'b0;
      alloc_idx_o  <= '0;
      reloc_vld_o  <= 1'b0;
      reloc_ok_o   <= 1'b0;
      reloc_idx_o  <= '0;
    end else begin
      alloc_vld_o  <= alloc_req_i;
      alloc_repl_o <= alloc_req_i && repl_ok;
      if (alloc_req_i) alloc_idx_o <= first_free;
      reloc_vld_o  <= reloc_req_i;
      reloc_ok_o   <= reloc_go;
      if (reloc_go) reloc_idx_o <= first_free;
    end
  end
endmodule

// File: rtl/pgc_repl_ctrl_chk.sv
module pgc_repl_ctrl_chk #(
  parameter int THW      = 8,
  parameter int THR_INIT = 32,
  parameter int THR_STEP = 8,
  parameter int THR_MAX  = 64
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           alloc_req_i,
  input logic           reloc_req_i,
  input logic           alloc_vld_o,
  input logic           alloc_repl_o,
  input logic           reloc_ok_o,
  input logic           evict_o,
  input logic           thrash_o,
  input logic [THW-1:0] threshold_o
);
  logic [THW:0]   up_c;
  logic [THW-1:0] raised_c;
  assign up_c     = {1'b0, threshold_o} + (THW+1)'(THR_STEP);
  assign raised_c = (up_c > (THW+1)'(THR_MAX)) ? THW'(THR_MAX) : up_c[THW-1:0];

  assert_thr_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    threshold_o >= THW'(THR_INIT) && threshold_o <= THW'(THR_MAX));

  assert_thrash_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thrash_o |=> !thrash_o);

  assert_thr_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thrash_o |=> threshold_o == $past(raised_c));

  assert_thr_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (threshold_o < $past(threshold_o)) |->
      (int'($past(threshold_o)) - int'(threshold_o) <= THR_STEP) && !$past(thrash_o));

  assert_reloc_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reloc_ok_o |-> $past(reloc_req_i) && !$past(alloc_req_i) && ($past(threshold_o) < THW'(THR_MAX)));

  assert_alloc_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_vld_o |-> $past(alloc_req_i));

  assert_grant_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_vld_o && alloc_repl_o && reloc_ok_o));

  assert_evict_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_o |-> !thrash_o);
endmodule

bind pgc_repl_ctrl pgc_repl_ctrl_chk #(
  .THW(THW), .THR_INIT(THR_INIT), .THR_STEP(THR_STEP), .THR_MAX(THR_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .alloc_req_i(alloc_req_i), .reloc_req_i(reloc_req_i),
  .alloc_vld_o(alloc_vld_o), .alloc_repl_o(alloc_repl_o), .reloc_ok_o(reloc_ok_o),
  .evict_o(evict_o), .thrash_o(thrash_o), .threshold_o(threshold_o)
);

// File: tb/pgc_repl_ctrl_bench.sv
module pgc_repl_ctrl_bench;
  localparam int IW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] total = '0;
  logic alloc_req = 0, reloc_req = 0, ref_set = 0;
  logic [IW-1:0] ref_idx = '0;
  logic alloc_vld, alloc_repl, reloc_vld, reloc_ok, evict, thrash;
  logic [IW-1:0] alloc_idx, reloc_idx, evict_idx;
  logic [7:0] thr;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int ev_n = 0, th_n = 0;
  int ev_log [0:255];
  int th_cyc [0:15];

  always #4 clk = ~clk;

  pgc_repl_ctrl u_pgc_repl_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .total_pages_i(total),
    .alloc_req_i(alloc_req), .reloc_req_i(reloc_req),
    .ref_set_i(ref_set), .ref_idx_i(ref_idx),
    .alloc_vld_o(alloc_vld), .alloc_repl_o(alloc_repl), .alloc_idx_o(alloc_idx),
    .reloc_vld_o(reloc_vld), .reloc_ok_o(reloc_ok), .reloc_idx_o(reloc_idx),
    .evict_o(evict), .evict_idx_o(evict_idx), .threshold_o(thr), .thrash_o(thrash)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    if (rst_n && evict) begin
      if (ev_n < 256) ev_log[ev_n] = int'(evict_idx);
      ev_n = ev_n + 1;
    end
    if (rst_n && thrash) begin
      if (th_n < 16) th_cyc[th_n] = cyc;
      th_n = th_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic with_reloc, output int repl, output int idx,
                          output int rok, output int ridx);
    @(negedge clk);
    alloc_req = 1'b1;
    reloc_req = with_reloc;
    @(negedge clk);
    alloc_req = 1'b0;
    reloc_req = 1'b0;
    #1;
    repl = int'(alloc_repl);
    idx  = int'(alloc_idx);
    rok  = int'(reloc_ok);
    ridx = int'(reloc_idx);
    chk("R2 alloc response valid", int'(alloc_vld), 1);
  endtask

  task automatic do_reloc(output int rok, output int ridx);
    @(negedge clk);
    reloc_req = 1'b1;
    @(negedge clk);
    reloc_req = 1'b0;
    #1;
    rok  = int'(reloc_ok);
    ridx = int'(reloc_idx);
    chk("R9 reloc response valid", int'(reloc_vld), 1);
  endtask

  task automatic wait_thrash(input int start_n, input int limit);
    for (int i = 0; i < limit && th_n == start_n; i++) @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R6 threshold at reset", int'(thr), 32);
    chk("R2 no alloc response at reset", int'(alloc_vld), 0);
    chk("R9 no reloc response at reset", int'(reloc_vld), 0);
    chk("R4 no eviction at reset", int'(evict), 0);
    chk("R6 no thrash at reset", int'(thrash), 0);
  endtask

  task automatic t_fill();
    int repl, idx, rok, ridx;
    for (int k = 0; k < 64; k++) begin
      do_alloc(1'b0, repl, idx, rok, ridx);
      chk("R2 replicated while free", repl, 1);
      chk("R2 lowest free frame", idx, k);
    end
    do_alloc(1'b0, repl, idx, rok, ridx);
    chk("R3 remote mode when pool empty", repl, 0);
    do_reloc(rok, ridx);
    chk("R9 reloc refused when pool empty", rok, 0);
    repeat (20) @(negedge clk);
    chk("R1 no sweep with zero watermarks", ev_n + th_n, 0);
  endtask

  task automatic t_fail_hot();
    int n0 = th_n;
    ev_n = 0;
    total = 16'd400;
    wait_thrash(n0, 300);
    chk("R1 sweep starts below low watermark", th_n, n0 + 1);
    chk("R4 hot frames kept", ev_n, 0);
    chk("R6 threshold raised", int'(thr), 40);
  endtask

  task automatic t_second_chance();
    int n0 = th_n;
    ev_n = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ref_set = 1'b1;
      ref_idx = IW'(k);
    end
    @(negedge clk);
    ref_set = 1'b0;
    repeat (200) @(negedge clk);
    #2;
    chk("R4 cold frames evicted", ev_n, 28);
    chk("R4 first evicted frame", ev_log[0], 4);
    chk("R5 sweep stops at high watermark", ev_log[27], 31);
    chk("R5 successful sweep has no pulse", th_n, n0);
    chk("R7 threshold lowered", int'(thr), 32);
  endtask

  task automatic t_priority();
    int repl, idx, rok, ridx;
    do_alloc(1'b1, repl, idx, rok, ridx);
    chk("R2 replicated after recovery", repl, 1);
    chk("R2 lowest free after evictions", idx, 4);
    chk("R9 reloc refused beside alloc", rok, 0);
    do_reloc(rok, ridx);
    chk("R9 reloc granted", rok, 1);
    chk("R9 reloc lowest free frame", ridx, 5);
  endtask

  task automatic t_backoff();
    int repl, idx, rok, ridx, n0;
    ev_n = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      ref_set = 1'b1;
      ref_idx = IW'(k);
    end
    @(negedge clk);
    ref_set = 1'b0;
    chk("R1 no sweep above low watermark", ev_n + th_n, 1);
    n0 = th_n;
    for (int k = 0; k < 7; k++) begin
      do_alloc(1'b0, repl, idx, rok, ridx);
      chk("R2 lowest free frame refill", idx, 6 + k);
    end
    wait_thrash(n0, 300);
    chk("R6 pulse on failed sweep", th_n, n0 + 1);
    chk("R4 no eviction of referenced frames", ev_n, 0);
    chk("R6 threshold raised again", int'(thr), 40);
    ev_n = 0;
    do_alloc(1'b0, repl, idx, rok, ridx);
    chk("R3 remote mode during backoff", repl, 0);
    do_reloc(rok, ridx);
    chk("R9 reloc granted during backoff", rok, 1);
    chk("R9 reloc frame during backoff", ridx, 13);
  endtask

  task automatic t_saturate();
    int n0 = th_n;
    int repl, idx, rok, ridx;
    int exp_thr [0:3];
    exp_thr[0] = 48; exp_thr[1] = 56; exp_thr[2] = 64; exp_thr[3] = 64;
    total = 16'd1300;
    for (int p = 0; p < 4; p++) begin
      wait_thrash(n0 + p, 400);
      chk("R6 threshold step and cap", int'(thr), exp_thr[p]);
      if (p == 0) chk("R10 sweep resumes at saved pointer", ev_log[0], 32);
    end
    chk("R8 interval doubled", th_cyc[n0 + 1] - th_cyc[n0], 98);
    chk("R8 interval doubled again", th_cyc[n0 + 2] - th_cyc[n0 + 1], 130);
    chk("R8 interval capped", th_cyc[n0 + 3] - th_cyc[n0 + 2], 130);
    do_reloc(rok, ridx);
    chk("R9 reloc disabled at threshold max", rok, 0);
    do_alloc(1'b0, repl, idx, rok, ridx);
    chk("R3 remote mode while thrashing", repl, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_fill();
    t_fail_hot();
    t_second_chance();
    t_priority();
    t_backoff();
    t_saturate();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule